// File: doc/BRIEF.md
# Word-to-Byte SDRAM Access Controller

This block lets a 32-bit host reach a single SDRAM device that has only an 8-bit data bus. Each host read or write opens one row, performs four single-byte column accesses on consecutive cycles, closes the row again, and returns one acknowledge. Byte order is big-endian: the most significant byte of the host word sits at the lowest column of the group of four.

The controller also brings the device up after reset and issues periodic auto-refresh. All device timing is held as whole clock-cycle parameters, rounded up from the nanosecond limits at a 15 ns clock. Refresh takes priority over a waiting host request and is issued only while every bank is closed. The host raises `host_req` with address, direction and write data, keeps them steady, and drops the request once it sees `host_ack`.

Top module: `sdram_x8_word_ctrl`

## Requirements
- R1: Device commands are the pin vector {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, MODE SET 0000. While reset is held, only NOP is shown, CKE is low, DQM is high and `host_ack` is low. After reset the bus stays at NOP for at least INIT_CYC cycles.
- R2: After that wait, the power-up order is PRECHARGE with A[10]=1, AUTO REFRESH, AUTO REFRESH, then MODE SET with BA=0 and A=0x020. That mode word means CAS latency 2 in A[6:4], sequential in A[3]=0 and one-beat bursts in A[2:0]=000. The gaps are at least T_RP, T_RFC and T_RFC, and at least T_MRD cycles pass after MODE SET before any further command. No ACTIVATE is issued before this order completes.
- R3: Host byte address `host_addr` maps bank = [24:23], row = [22:10] and column = {[9:2], byte index}. Bits [1:0] are ignored.
- R4: An access is one ACTIVATE followed by exactly four column commands of the same kind to the same bank on consecutive cycles. The first comes exactly T_RCD cycles after ACTIVATE, A[1:0] counts 0,1,2,3, and A[10] is 0.
- R5: On a write, byte index 0 carries `host_wdata[31:24]` and index 3 carries `[7:0]`. The controller drives DQ only in cycles that carry a WRITE.
- R6: On a read, each byte is taken from DQ on the second rising edge after the device registers the READ. The first byte lands in `host_rdata[31:24]` and the last in `[7:0]`.
- R7: The single-bank PRECHARGE closing an access comes at least T_RAS after ACTIVATE, T_WR after the last WRITE and CAS_LAT after the last READ. ACTIVATE, AUTO REFRESH and MODE SET each come at least T_RP after any PRECHARGE.
- R8: Successive ACTIVATEs are at least T_RC apart. After an AUTO REFRESH, no command is issued for T_RFC cycles.
- R9: Refresh becomes due every REF_INT cycles, counted without pause from the end of power-up. A due refresh is issued before a waiting host request, and only when no row is open. The gap between refreshes never exceeds REF_INT plus the length of one access.
- R10: `host_ack` is a one-cycle pulse, exactly one per request. For a write it comes in the cycle after the fourth WRITE. For a read it comes CAS_LAT+1 cycles after the fourth READ, and `host_rdata` holds the full word in that cycle.
- R11: After power-up completes, CKE stays high and DQM stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the controller and the device |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 25 | Byte address within the 32 MB window |
| host_wdata | input | 32 | Write word |
| host_rdata | output | 32 | Assembled read word |
| host_ack | output | 1 | One-cycle completion pulse |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Row, column or mode address |
| sd_dq | inout | 8 | Bidirectional data |

## Verification
The embedded properties check every cycle that the command spacing rules hold: RCD before column commands, the precharge window, RP, RC and RFC. They also check that refresh only happens with the row closed, that the acknowledge is a single pulse, and that the CKE and DQM levels are correct once running. Byte ordering, the address split, the exact read-capture edge, the power-up order and the bound on refresh gaps under steady traffic depend on data and history. The bench's device model shows these by storing bytes at decoded locations and returning them with the set latency.

// File: rtl/sdram_x8_word_ctrl.sv
module sdram_x8_word_ctrl #(
  parameter int T_RCD    = 2,
  parameter int T_RP     = 2,
  parameter int T_RAS    = 3,
  parameter int T_RC     = 5,
  parameter int T_RFC    = 5,
  parameter int T_WR     = 2,
  parameter int T_MRD    = 2,
  parameter int CAS_LAT  = 2,
  parameter int REF_INT  = 520,
  parameter int INIT_CYC = 13334
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [24:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_ack,
  output logic        sd_cke,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic        sd_dqm,
  output logic [1:0]  sd_ba,
  output logic [12:0] sd_a,
  inout  wire  [7:0]  sd_dq
);
  localparam int RAS_FLOOR = T_RAS - T_RCD - 3;
  localparam int WR_BASE   = (T_WR > 2) ? T_WR : 2;
  localparam int RD_BASE   = (CAS_LAT > 2) ? CAS_LAT : 2;
  localparam int POST_WR   = (WR_BASE > RAS_FLOOR) ? WR_BASE : RAS_FLOOR;
  localparam int POST_RD   = (RD_BASE > RAS_FLOOR) ? RD_BASE : RAS_FLOOR;
  localparam int CW        = $clog2(INIT_CYC + 256);
  localparam int RW        = $clog2(REF_INT + 1);
  localparam logic [12:0] MODE_WORD = 13'(CAS_LAT << 4);

  typedef enum logic [3:0] {
    S_PWR, S_IPRE, S_IREF1, S_IREF2, S_MRS, S_IDLE, S_REF, S_ACT, S_COL, S_POST, S_PRE
  } state_t;

  typedef enum logic [3:0] {
    C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010, C_ACT = 4'b0011,
    C_WR  = 4'b0100, C_RD  = 4'b0101, C_NOP = 4'b0111
  } cmd_t;

  state_t st;
  cmd_t   cmd;
  logic [CW-1:0] cnt;
  logic [RW-1:0] ref_cnt;
  logic          ref_pend;
  logic [1:0]    bank, bidx, cap_cnt;
  logic [7:0]    wcol;
  logic          wr;
  logic [31:0]   wsh, rsh;
  logic [7:0]    dq_o;
  logic          dq_oe, ack, cke, dqm;
  logic [1:0]    ba_o;
  logic [12:0]   a_o;
  logic [CAS_LAT-1:0] rd_vld;
  logic          unused_lsb;

  wire       done    = (cnt == '0);
  wire       capture = rd_vld[CAS_LAT-1];
  wire       in_init = (st == S_PWR) || (st == S_IPRE) || (st == S_IREF1) ||
                       (st == S_IREF2) || (st == S_MRS);
  wire       col_go  = (st == S_ACT && done) || (st == S_COL && bidx != 2'd3);
  wire [1:0] nidx    = (st == S_ACT) ? 2'd0 : bidx + 2'd1;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_dq      = dq_oe ? dq_o : 8'bz;
  assign sd_cke     = cke;
  assign sd_dqm     = dqm;
  assign sd_ba      = ba_o;
  assign sd_a       = a_o;
  assign host_rdata = rsh;
  assign host_ack   = ack;
  assign unused_lsb = ^host_addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PWR;  cnt <= CW'(INIT_CYC - 1);  cmd <= C_NOP;
      cke <= 1'b0;  dqm <= 1'b1;  ba_o <= '0;  a_o <= '0;
      dq_oe <= 1'b0;  dq_o <= '0;  ack <= 1'b0;
      bank <= '0;  bidx <= '0;  wcol <= '0;  wr <= 1'b0;
      wsh <= '0;  rsh <= '0;  cap_cnt <= '0;  rd_vld <= '0;
    end else begin
      cmd <= C_NOP;  dq_oe <= 1'b0;  ack <= 1'b0;  cke <= 1'b1;
      rd_vld <= CAS_LAT'({rd_vld, cmd == C_RD});
      if (!done) cnt <= cnt - 1'b1;
      case (st)
        S_PWR:   if (done) begin cmd <= C_PRE; a_o <= 13'h400; st <= S_IPRE;  cnt <= CW'(T_RP - 1);  end
        S_IPRE:  if (done) begin cmd <= C_REF; st <= S_IREF1; cnt <= CW'(T_RFC - 1); end
        S_IREF1: if (done) begin cmd <= C_REF; st <= S_IREF2; cnt <= CW'(T_RFC - 1); end
        S_IREF2: if (done) begin
          cmd <= C_MRS; a_o <= MODE_WORD; ba_o <= '0; st <= S_MRS; cnt <= CW'(T_MRD - 1);
        end
        S_MRS:   if (done) begin st <= S_IDLE; dqm <= 1'b0; end
        S_IDLE:
          if (ref_pend) begin
            cmd <= C_REF; st <= S_REF; cnt <= CW'(T_RFC - 1);
          end else if (host_req) begin
            cmd  <= C_ACT;
            ba_o <= host_addr[24:23];  a_o <= host_addr[22:10];
            bank <= host_addr[24:23];  wcol <= host_addr[9:2];
            wr   <= host_we;           wsh  <= host_wdata;
            st   <= S_ACT;             cnt  <= CW'(T_RCD - 1);
          end
        S_REF:   if (done) st <= S_IDLE;
        S_ACT:   if (done) st <= S_COL;
        S_COL:
          if (bidx == 2'd3) begin
            st  <= S_POST;
            cnt <= wr ? CW'(POST_WR - 2) : CW'(POST_RD - 2);
            if (wr) ack <= 1'b1;
          end
        S_POST:  if (done) begin cmd <= C_PRE; a_o <= '0; ba_o <= bank; st <= S_PRE; cnt <= CW'(T_RP - 1); end
        S_PRE:   if (done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (col_go) begin
        cmd  <= wr ? C_WR : C_RD;
        a_o  <= {3'b000, wcol, nidx};
        ba_o <= bank;
        bidx <= nidx;
        if (wr) begin
          dq_oe <= 1'b1;
          dq_o  <= wsh[31:24];
          wsh   <= {wsh[23:0], 8'h00};
        end
      end
      if (capture) begin
        rsh     <= {rsh[23:0], sd_dq};
        cap_cnt <= cap_cnt + 2'd1;
        if (cap_cnt == 2'd3) ack <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= RW'(REF_INT - 1);
      ref_pend <= 1'b0;
    end else if (in_init) begin
      ref_cnt  <= RW'(REF_INT - 1);
      ref_pend <= 1'b0;
    end else begin
      if (st == S_IDLE && ref_pend) ref_pend <= 1'b0;
      if (ref_cnt == '0) begin
        ref_cnt  <= RW'(REF_INT - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt - 1'b1;
      end
    end
  end

  logic [9:0] since_act, since_pre, since_ref, since_wr, since_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 10'd1023; since_pre <= 10'd1023; since_ref <= 10'd1023;
      since_wr  <= 10'd1023; since_rd  <= 10'd1023;
    end else begin
      since_act <= (cmd == C_ACT) ? 10'd1 : (since_act == 10'd1023 ? since_act : since_act + 10'd1);
      since_pre <= (cmd == C_PRE) ? 10'd1 : (since_pre == 10'd1023 ? since_pre : since_pre + 10'd1);
      since_ref <= (cmd == C_REF) ? 10'd1 : (since_ref == 10'd1023 ? since_ref : since_ref + 10'd1);
      since_wr  <= (cmd == C_WR)  ? 10'd1 : (since_wr  == 10'd1023 ? since_wr  : since_wr  + 10'd1);
      since_rd  <= (cmd == C_RD)  ? 10'd1 : (since_rd  == 10'd1023 ? since_rd  : since_rd  + 10'd1);
    end
  end

  a_r4_trcd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> since_act >= 10'(T_RCD));
  a_r7_pre_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> (since_wr >= 10'(T_WR) && since_rd >= 10'(CAS_LAT) && since_act >= 10'(T_RAS)));
  a_r7_trp: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT || cmd == C_REF || cmd == C_MRS) |-> since_pre >= 10'(T_RP));
  a_r8_trc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> since_act >= 10'(T_RC));
  a_r8_trfc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NOP) |-> since_ref >= 10'(T_RFC));
  a_r9_ref_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |-> since_pre <= since_act);
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
  a_r11_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_init) |-> (sd_cke && !sd_dqm));
endmodule

// File: tb/test_sdram_x8_word_ctrl.sv
module test_sdram_x8_word_ctrl;
  localparam int T_RCD = 2, T_RP = 2, T_RAS = 3, T_RC = 5, T_RFC = 5, T_WR = 2, T_MRD = 2;
  localparam int CL = 2, REF_INT = 100, INIT_CYC = 40, SLACK = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        host_req = 1'b0, host_we = 1'b0;
  logic [24:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ack;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm;
  logic [1:0]  sd_ba;
  logic [12:0] sd_a;
  wire  [7:0]  sd_dq;
  logic [7:0]  m_dq = '0;
  logic        m_oe = 1'b0;
  assign sd_dq = m_oe ? m_dq : 8'bz;

  sdram_x8_word_ctrl #(.REF_INT(REF_INT), .INIT_CYC(INIT_CYC)) i_sdram_x8_word_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq(sd_dq));

  int checks = 0, errors = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] dflt(int k);
    return 8'(k ^ (k >> 8) ^ 8'h3C);
  endfunction

  function automatic int key_of(logic [24:0] addr, int i);
    return int'({addr[24:23], addr[22:10], addr[9:2], 2'(i)});
  endfunction

  int pcnt = 0;
  always @(posedge clk) if (rst_n) pcnt <= pcnt + 1;

  logic [7:0] mem [int];
  logic [31:0] exp_words [int];
  int rq_due[$];
  logic [7:0] rq_dat[$];
  int open_row[4] = '{-1, -1, -1, -1};
  int last_act = -1000, last_pre = -1000, last_ref = -1000, last_wr = -1000;
  int last_rd = -1000, last_mrs = -1000, last_col = -1000;
  int init_step = 0, exp_idx = 4, act_ba = 0, ref_count = 0;
  bit in_txn = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] c;
      int key;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (c != 4'b0111) begin
        chk(pcnt - last_mrs >= T_MRD, "R2", "gap after mode set", pcnt - last_mrs, T_MRD);
        chk(pcnt - last_ref >= T_RFC, "R8", "command inside refresh recovery", pcnt - last_ref, T_RFC);
        if (init_step < 4) begin
          case (init_step)
            0: begin
              chk(c == 4'b0010 && sd_a[10], "R2", "first init command", c, 4'b0010);
              chk(pcnt >= INIT_CYC, "R1", "power-up wait", pcnt, INIT_CYC);
            end
            1, 2: chk(c == 4'b0001, "R2", "init refresh", c, 4'b0001);
            default: begin
              chk(c == 4'b0000, "R2", "init mode set", c, 4'b0000);
              chk(sd_a == 13'h020 && sd_ba == 2'd0, "R2", "mode word", sd_a, 13'h020);
              chk(pcnt - last_ref >= T_RFC, "R2", "refresh to mode gap", pcnt - last_ref, T_RFC);
            end
          endcase
          init_step++;
        end
      end
      case (c)
        4'b0011: begin
          chk(init_step == 4, "R2", "activate before init done", init_step, 4);
          chk(open_row[sd_ba] == -1, "R7", "activate on open bank", open_row[sd_ba], -1);
          chk(pcnt - last_act >= T_RC, "R8", "activate spacing", pcnt - last_act, T_RC);
          chk(pcnt - last_pre >= T_RP, "R7", "precharge to activate", pcnt - last_pre, T_RP);
          open_row[sd_ba] = int'(sd_a);
          act_ba = sd_ba; exp_idx = 0; last_act = pcnt;
        end
        4'b0101, 4'b0100: begin
          chk(open_row[sd_ba] != -1 && sd_ba == act_ba, "R4", "column to closed bank", sd_ba, act_ba);
          chk(sd_a[10] == 1'b0 && sd_a[1:0] == 2'(exp_idx), "R4", "byte index", sd_a[1:0], exp_idx);
          if (exp_idx == 0)
            chk(pcnt - last_act == T_RCD, "R4", "activate to first column", pcnt - last_act, T_RCD);
          else
            chk(pcnt == last_col + 1, "R4", "column spacing", pcnt - last_col, 1);
          exp_idx++; last_col = pcnt;
          key = int'({sd_ba, 13'(open_row[sd_ba]), sd_a[9:0]});
          if (c == 4'b0100) begin
            chk(!$isunknown(sd_dq), "R5", "write data not driven", 0, 1);
            mem[key] = sd_dq; last_wr = pcnt;
          end else begin
            rq_due.push_back(pcnt + CL);
            rq_dat.push_back(mem.exists(key) ? mem[key] : dflt(key));
            last_rd = pcnt;
          end
        end
        4'b0010: begin
          if (init_step == 4 && !sd_a[10]) begin
            chk(exp_idx == 4, "R4", "column count before precharge", exp_idx, 4);
            chk(pcnt - last_act >= T_RAS, "R7", "tRAS", pcnt - last_act, T_RAS);
            chk(pcnt - last_wr >= T_WR, "R7", "tWR", pcnt - last_wr, T_WR);
            chk(pcnt - last_rd >= CL, "R7", "read to precharge", pcnt - last_rd, CL);
          end
          if (sd_a[10]) open_row = '{-1, -1, -1, -1}; else open_row[sd_ba] = -1;
          last_pre = pcnt;
        end
        4'b0001: begin
          chk(open_row[0] == -1 && open_row[1] == -1 && open_row[2] == -1 && open_row[3] == -1,
              "R9", "refresh with row open", 1, 0);
          chk(pcnt - last_pre >= T_RP, "R7", "precharge to refresh", pcnt - last_pre, T_RP);
          if (init_step == 4)
            chk(pcnt - last_ref <= REF_INT + SLACK, "R9", "refresh gap", pcnt - last_ref, REF_INT + SLACK);
          last_ref = pcnt; ref_count++;
        end
        4'b0000: last_mrs = pcnt;
        default: ;
      endcase
      if (c != 4'b0100 && !m_oe)
        chk(sd_dq === 8'bz, "R5", "controller drives DQ outside write", sd_dq, 0);
      if (init_step == 4 && pcnt > last_mrs + T_MRD)
        chk(sd_cke && !sd_dqm, "R11", "cke/dqm levels", {sd_cke, sd_dqm}, 2'b10);
      if (host_ack && !in_txn) chk(1'b0, "R10", "spurious acknowledge", 1, 0);
      m_oe = 1'b0;
      if (rq_due.size() > 0 && rq_due[0] == pcnt) begin
        m_dq = rq_dat[0]; m_oe = 1'b1;
        void'(rq_due.pop_front()); void'(rq_dat.pop_front());
      end
    end
  end

  task automatic access(bit we, logic [24:0] addr, logic [31:0] wd, output logic [31:0] rd);
    int n = 0;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd; in_txn = 1'b1;
    do begin
      @(negedge clk); n++;
    end while (!host_ack && n < 500);
    chk(n < 500, "R10", "no acknowledge", n, 0);
    rd = host_rdata;
    if (we) chk(pcnt == last_wr + 1, "R10", "write ack cycle", pcnt - last_wr, 1);
    else    chk(pcnt == last_rd + CL + 1, "R10", "read ack cycle", pcnt - last_rd, CL + 1);
    host_req = 1'b0;
    @(negedge clk);
    chk(!host_ack, "R10", "ack longer than one cycle", host_ack, 0);
    in_txn = 1'b0;
  endtask

  task automatic wr_word(logic [24:0] addr, logic [31:0] d);
    logic [31:0] dummy;
    access(1'b1, addr, d, dummy);
    for (int i = 0; i < 4; i++) begin
      int k = key_of(addr, i);
      chk(mem.exists(k) && mem[k] == d[31 - 8*i -: 8], "R3/R5", "byte placement",
          mem.exists(k) ? mem[k] : 8'hxx, d[31 - 8*i -: 8]);
    end
    exp_words[int'(addr[24:2])] = d;
  endtask

  task automatic rd_word(logic [24:0] addr);
    logic [31:0] got, exp;
    access(1'b0, addr, 32'h0, got);
    if (exp_words.exists(int'(addr[24:2]))) exp = exp_words[int'(addr[24:2])];
    else for (int i = 0; i < 4; i++) exp = {exp[23:0], dflt(key_of(addr, i))};
    chk(got == exp, "R6", "read word", got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    int n = 0, r0;
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && !sd_cke && sd_dqm && !host_ack,
        "R1", "reset state", {sd_cke, sd_dqm, host_ack}, 3'b010);
    @(posedge clk); #1 rst_n = 1'b1;
    while (!(init_step == 4 && pcnt > last_mrs + 5) && n < 2000) begin @(negedge clk); n++; end
    chk(init_step == 4, "R2", "power-up sequence complete", init_step, 4);

    for (int i = 0; i < 4; i++) wr_word(25'(4 * i), 32'h1234_5678);
    for (int i = 0; i < 4; i++) rd_word(25'(4 * i));
    wr_word(25'h1FF_FFFC, 32'hDEAD_BEEF);
    wr_word(25'h180_0000, 32'h0102_0304);
    wr_word(25'h07F_FC00, 32'hA5C3_0F96);
    rd_word(25'h1FF_FFFC);
    rd_word(25'h180_0000);
    rd_word(25'h07F_FC00);
    wr_word(25'h000_0103, 32'hCAFE_F00D);
    rd_word(25'h000_0100);
    rd_word(25'h0AB_CDE0);
    wr_word(25'h000_0004, 32'h8765_4321);
    rd_word(25'h000_0004);

    for (int i = 0; i < 60; i++) begin
      logic [24:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = {lfsr[24:23], 10'(lfsr[19:12]), 3'b000, lfsr[9:8], 6'(lfsr[5:0]), 2'b00};
      if (lfsr[28]) wr_word(a, lfsr ^ 32'h5A5A_0000);
      else rd_word(a);
    end

    r0 = ref_count;
    repeat (400) @(negedge clk);
    chk(ref_count - r0 >= 3, "R9", "refreshes while idle", ref_count - r0, 3);
    rd_word(25'h1FF_FFFC);
    finish_up();
  end
endmodule